// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Atomic Set/Clear Writes

This block is a 32-pin general-purpose I/O controller with a register port, split into a low bank (pins 0 to 15) and a high bank (pins 16 to 31). The two banks have the same register set. Each per-pin control register is written with a set/clear word. A one in the lower half turns the control on for the matching pin. A one in the upper half turns it off. Several agents can therefore change single pins without a read-modify-write sequence and without disturbing each other's pins.

Each pin has six stored controls: drive value, drive enable, input enable, two output-override selects and one input-function select. The block also synchronises the pin inputs and exposes three more views of them. One is a readback of the synchronised levels. The other two are rising-edge and falling-edge status latches, which are cleared by writing a one to the status bit. Reads are combinational from the address. A write takes effect at the clock edge on which `req_i` and `we_i` are both high.

Top module: `gpio_atomic_bank`

## Requirements
- R1: On a write to a control register, each one in `wdata_i[15:0]` bit n sets that control for pin n of the addressed bank.
- R2: Each one in `wdata_i[31:16]` bit n+16 clears that control for pin n. Pins whose two bits are both zero keep their value.
- R3: If one write sets and clears the same pin, the control ends up cleared.
- R4: Byte address bit 7 selects the bank (0x80 is the high bank). Word offsets within a bank:
  - 0x00 drive value
  - 0x04 drive enable
  - 0x08 input enable
  - 0x0C output override A
  - 0x10 output override B
  - 0x14 input function select
  - 0x18 readback
  - 0x1C rising-edge status
  - 0x20 falling-edge status

  Unaligned or unmapped accesses write nothing and read zero.
- R5: A read returns the bank's 16 pins in `rdata_o[15:0]`, with bit n for pin n. `rdata_o[31:16]` always reads zero.
- R6: Pins 23, 29, 30 and 31 are reserved. Every register reads zero for them, writes do not change them, and they are never driven.
- R7: `pin_oe_o` equals drive enable with both output overrides clear. `pin_o` equals drive value ANDed with `pin_oe_o`.
- R8: Readback returns the pin input through a two-flop synchroniser, ANDed with input enable. It reflects a change two clock edges after the change.
- R9: A rising-edge or falling-edge status bit latches when the synchronised level of a pin changes in that direction while its input enable is set. The bit is readable three clock edges after the pin changes. No edge is latched while input enable is clear.
- R10: A write to an edge-status register clears each bit written as one, using all 16 low data bits. It does not use the set/clear encoding. A new edge in the same cycle wins over the clear.
- R11: After reset every control, status bit and output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pin_i | input | 32 | Pin input levels |
| pin_o | output | 32 | Pin output values |
| pin_oe_o | output | 32 | Pin output enables |

## Verification
A wrong control bit shows up on `pin_o`/`pin_oe_o` on the clock edge after the write. It also shows up at once on `rdata_o` when that register is read back. A fault in the set/clear decode, such as a swapped half, a missing clear priority or a bank mixup, therefore appears within one cycle of the offending write. Faults in the synchroniser or edge path show up only after the two- or three-edge input latency. The bench therefore samples readback and status after that latency, and once more after a write-one-to-clear.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned NUM_CTL = 6;
  localparam int unsigned IDX_W   = 5;

  typedef enum logic [IDX_W-1:0] {
    REG_OVAL  = 5'd0,
    REG_OEN   = 5'd1,
    REG_IEN   = 5'd2,
    REG_OAUXA = 5'd3,
    REG_OAUXB = 5'd4,
    REG_IAUX  = 5'd5,
    REG_RDBK  = 5'd6,
    REG_PEDGE = 5'd7,
    REG_NEDGE = 5'd8
  } reg_idx_e;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  // clear has priority over set
  always_comb q_d = ((q_o | set_i) & ~clr_i) & ~RSVD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= q_d;
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      lvl_o  <= '0;
      prev_o <= '0;
    end else begin
      s1_q   <= pin_i;
      lvl_o  <= s1_q;
      prev_o <= lvl_o;
    end
  end
endmodule

// File: rtl/gpio_edge_stat.sv
module gpio_edge_stat #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_pos_i,
  input  logic         clr_neg_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] neg_o
);
  logic [W-1:0] rise, fall, pos_d, neg_d;

  always_comb begin
    rise  = lvl_i & ~prev_i & en_i & ~RSVD;
    fall  = ~lvl_i & prev_i & en_i & ~RSVD;
    pos_d = pos_o;
    neg_d = neg_o;
    if (clr_pos_i) pos_d = pos_d & ~w1c_i;
    if (clr_neg_i) neg_d = neg_d & ~w1c_i;
    // fresh edge wins over a clear in the same cycle
    pos_d = pos_d | rise;
    neg_d = neg_d | fall;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o <= '0;
      neg_o <= '0;
    end else begin
      pos_o <= pos_d;
      neg_o <= neg_d;
    end
  end
endmodule

// File: rtl/gpio_atomic_bank.sv
module gpio_atomic_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned BANK_W    = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [NUM_PINS-1:0] RSVD_MASK = 32'hE080_0000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  localparam int unsigned NUM_BANKS = NUM_PINS / BANK_W;
  localparam int unsigned BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned IDX_MSB   = ADDR_W - 1 - BSEL_W;

  logic [NUM_CTL-1:0][NUM_PINS-1:0] ctl_q;
  logic [NUM_PINS-1:0] lvl, prev, rdbk, pos_q, neg_q;
  logic [BSEL_W-1:0]   bank_sel;
  logic [IDX_W-1:0]    reg_idx;
  logic                acc_ok, wr_ok;

  assign bank_sel = addr_i[ADDR_W-1 -: BSEL_W];
  assign reg_idx  = IDX_W'(addr_i[IDX_MSB:2]);
  assign acc_ok   = (addr_i[1:0] == 2'b00);
  assign wr_ok    = req_i & we_i & acc_ok;

  gpio_pin_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .lvl_o (lvl),
    .prev_o(prev)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_hit;
    assign bank_hit = wr_ok & (bank_sel == BSEL_W'(b));

    for (genvar c = 0; c < NUM_CTL; c++) begin : g_ctl
      gpio_setclr_reg #(
        .W   (BANK_W),
        .RSVD(RSVD_MASK[b*BANK_W +: BANK_W])
      ) u_reg (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .wr_i  (bank_hit && (reg_idx == IDX_W'(c))),
        .set_i (wdata_i[BANK_W-1:0]),
        .clr_i (wdata_i[2*BANK_W-1:BANK_W]),
        .q_o   (ctl_q[c][b*BANK_W +: BANK_W])
      );
    end

    gpio_edge_stat #(
      .W   (BANK_W),
      .RSVD(RSVD_MASK[b*BANK_W +: BANK_W])
    ) u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_i    (lvl[b*BANK_W +: BANK_W]),
      .prev_i   (prev[b*BANK_W +: BANK_W]),
      .en_i     (ctl_q[REG_IEN][b*BANK_W +: BANK_W]),
      .clr_pos_i(bank_hit && (reg_idx == REG_PEDGE)),
      .clr_neg_i(bank_hit && (reg_idx == REG_NEDGE)),
      .w1c_i    (wdata_i[BANK_W-1:0]),
      .pos_o    (pos_q[b*BANK_W +: BANK_W]),
      .neg_o    (neg_q[b*BANK_W +: BANK_W])
    );
  end

  assign rdbk     = lvl & ctl_q[REG_IEN] & ~RSVD_MASK;
  assign pin_oe_o = ctl_q[REG_OEN] & ~(ctl_q[REG_OAUXA] | ctl_q[REG_OAUXB]) & ~RSVD_MASK;
  assign pin_o    = ctl_q[REG_OVAL] & pin_oe_o;

  always_comb begin
    rdata_o = '0;
    if (acc_ok && (int'(bank_sel) < NUM_BANKS)) begin
      if (int'(reg_idx) < NUM_CTL)
        rdata_o[BANK_W-1:0] = ctl_q[reg_idx][bank_sel*BANK_W +: BANK_W];
      else if (reg_idx == REG_RDBK)
        rdata_o[BANK_W-1:0] = rdbk[bank_sel*BANK_W +: BANK_W];
      else if (reg_idx == REG_PEDGE)
        rdata_o[BANK_W-1:0] = pos_q[bank_sel*BANK_W +: BANK_W];
      else if (reg_idx == REG_NEDGE)
        rdata_o[BANK_W-1:0] = neg_q[bank_sel*BANK_W +: BANK_W];
    end
  end
endmodule

// File: rtl/gpio_atomic_bank_chk.sv
module gpio_atomic_bank_chk #(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [NUM_PINS-1:0] RSVD_MASK = 32'hE080_0000
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o
);
  logic wr_oen_lo, wr_ctl_zero;
  assign wr_oen_lo   = req_i && we_i && (addr_i == 8'h04);
  assign wr_ctl_zero = req_i && we_i && (addr_i[1:0] == 2'b00) &&
                       (addr_i[6:2] < 5'd6) && (wdata_i == 32'h0);

  assert_rsvd_undriven_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & RSVD_MASK) == '0);

  assert_upper_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:16] == 16'h0);

  assert_clear_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_oen_lo && wdata_i[0] && wdata_i[16]) |=> !pin_oe_o[0]);

  assert_zero_write_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctl_zero |=> ($stable(pin_oe_o) && $stable(pin_o)));

  assert_drive_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~pin_oe_o) == '0);
endmodule

bind gpio_atomic_bank gpio_atomic_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .ADDR_W   (ADDR_W),
  .RSVD_MASK(RSVD_MASK)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pin_o   (pin_o),
  .pin_oe_o(pin_oe_o)
);

// File: tb/tb_gpio_atomic_bank.sv
`timescale 1ns/1ps
module tb_gpio_atomic_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o, pin_oe_o;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  gpio_atomic_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    req_i = 1'b0;
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 pin_oe after reset", pin_oe_o, 32'h0);
    check("R11 pin_o after reset", pin_o, 32'h0);
    for (int k = 0; k < 9; k++) begin
      bus_rd(8'(k*4), rd);
      check("R11 low bank reg after reset", rd, 32'h0);
    end
  endtask

  task automatic t_set_clear;
    bus_wr(8'h00, 32'h0000_0005);
    bus_wr(8'h04, 32'h0000_0007);
    check("R1 pin_oe after set", pin_oe_o, 32'h7);
    check("R7 pin_o = val & oe", pin_o, 32'h5);
    bus_rd(8'h00, rd);
    check("R1/R5 readback of drive value", rd, 32'h5);
    bus_wr(8'h04, 32'h0002_0000);
    check("R2 clear bit 1 only", pin_oe_o, 32'h5);
    bus_wr(8'h04, 32'h0000_0000);
    check("R2 zero write no change", pin_oe_o, 32'h5);
    bus_wr(8'h04, 32'h0001_0001);
    check("R3 clear beats set", pin_oe_o, 32'h4);
  endtask

  task automatic t_aux_override;
    bus_wr(8'h0C, 32'h0000_0004);
    check("R7 override A drops drive", pin_oe_o, 32'h0);
    bus_wr(8'h0C, 32'h0004_0000);
    bus_wr(8'h10, 32'h0000_0004);
    check("R7 override B drops drive", pin_oe_o, 32'h0);
    bus_wr(8'h10, 32'h0004_0000);
    check("R7 drive restored", pin_o, 32'h4);
    bus_wr(8'h14, 32'h0000_8001);
    bus_rd(8'h14, rd);
    check("R4 input function register", rd, 32'h8001);
  endtask

  task automatic t_high_bank;
    bus_wr(8'h80, 32'h0000_0010);
    bus_wr(8'h84, 32'h0000_0010);
    check("R4 high bank drives pin 20", pin_o & 32'h0010_0000, 32'h0010_0000);
    bus_rd(8'h00, rd);
    check("R4 low bank untouched", rd, 32'h5);
    bus_wr(8'h84, 32'h0000_FFFF);
    bus_rd(8'h84, rd);
    check("R6 reserved bits read zero", rd, 32'h0000_1F7F);
    check("R6 reserved pins not driven", pin_oe_o & 32'hE080_0000, 32'h0);
    bus_rd(8'h86, rd);
    check("R4 unaligned reads zero", rd, 32'h0);
    bus_wr(8'h84, 32'hFFFF_0000);
  endtask

  task automatic t_readback;
    bus_wr(8'h08, 32'h0000_0004);
    @(negedge clk); pin_i[2] = 1'b1; pin_i[3] = 1'b1;
    wait_clk(2);
    bus_rd(8'h18, rd);
    check("R8 readback gated by input enable", rd, 32'h4);
  endtask

  task automatic t_edges;
    bus_rd(8'h1C, rd);
    check("R9 rising latched on enabled pin", rd, 32'h4);
    @(negedge clk); pin_i[2] = 1'b0; pin_i[3] = 1'b0;
    wait_clk(4);
    bus_rd(8'h20, rd);
    check("R9 falling latched, disabled pin ignored", rd, 32'h4);
    bus_wr(8'h1C, 32'h0000_0004);
    bus_rd(8'h1C, rd);
    check("R10 rising cleared by write one", rd, 32'h0);
    bus_rd(8'h20, rd);
    check("R10 other status untouched", rd, 32'h4);
    bus_wr(8'h20, 32'h0004_0000);
    bus_rd(8'h20, rd);
    check("R10 upper half does not clear status", rd, 32'h4);
    bus_wr(8'h20, 32'h0000_0004);
    bus_rd(8'h20, rd);
    check("R10 falling cleared", rd, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(1);
    t_reset();
    t_set_clear();
    t_aux_override();
    t_high_bank();
    t_readback();
    t_edges();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule